// File: doc/BRIEF.md
# Iterative Second-Order ODE Stepper

This block advances the numerical solution of a second-order differential equation one step at a time until the running abscissa reaches a bound. After a `start` request it captures an initial point (`x`, `y`, `u`), a step size `dx` and a bound `a`. It then repeats an update step. Each step produces a new abscissa `x + dx`, a new slope `u - 3*x*u*dx - 3*y*dx` and a new ordinate `y + u*dx`. When the loop stops, the final ordinate appears on `y_out` together with a one-cycle `done` pulse.

Every update step runs on a small shared datapath: two fixed-point multipliers and two adder/ALU units. These are time-shared over four control steps, and the schedule and binding are fixed at design time. A controller walks the control steps, and operand multiplexers steer each step's operands into the units. Intermediate products and sums are held in dedicated registers between steps. All values are signed Q8.8.

Top module: `ode_stepper`

## Requirements
- R1: `start` is sampled only while the block is idle. A `start` that arrives during a run changes neither the result nor the run length.
- R2: Each update step forms the new abscissa as `x + dx` (16-bit wrap-around addition).
- R3: Each update step forms the new slope as `u - ((3*x)*(u*dx)) - ((3*y)*dx)`, using the Q8.8 product of R9 for every multiplication.
- R4: Each update step forms the new ordinate as `y + u*dx`. All three state values (x, u, y) are replaced together at the end of the step.
- R5: After a step, the loop continues while the new abscissa is strictly below `a` in a signed compare. It stops once the new abscissa is equal to or greater than `a`.
- R6: If the first new abscissa already reaches `a`, exactly one update step is performed.
- R7: Each update step takes exactly 4 clock cycles. For N steps, `done` rises 4*N cycles after the clock edge that accepted `start`.
- R8: `done` is high for exactly one cycle. `y_out` keeps the result until the next accepted `start`.
- R9: All values are signed Q8.8 (8 fractional bits). A product is the full signed product shifted right arithmetically by 8 and truncated to 16 bits. The constant three is encoded as 768.
- R10: After reset, `done` is 0 and `y_out` is 0. A reset during a run abandons the run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a solve; accepted only when idle |
| x_in | input | 16 | Initial abscissa, Q8.8 |
| y_in | input | 16 | Initial ordinate, Q8.8 |
| u_in | input | 16 | Initial slope, Q8.8 |
| dx_in | input | 16 | Step size, Q8.8 |
| a_in | input | 16 | Abscissa bound, Q8.8 |
| y_out | output | 16 | Final ordinate, held until the next start |
| done | output | 1 | One-cycle pulse when the result is ready |

## Verification
Two functions can coincide in one cycle. A new `start` request can land while a solve is running, and a `start` can arrive on the cycle in which a running solve commits its state registers. The bench injects a `start` with different operands in the middle of a run, and another on the final commit cycle. It judges both by the final `y_out` and by the cycle count, which must match an unperturbed run. A run cut off by reset is judged by `done` and `y_out` returning to zero, and by a clean rerun afterwards.

// File: rtl/ode_stepper_pkg.sv
package ode_stepper_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ONE  = 3'd1,
    PH_TWO  = 3'd2,
    PH_THR  = 3'd3,
    PH_FOUR = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    AOP_ADD = 2'd0,
    AOP_SUB = 2'd1,
    AOP_LT  = 2'd2
  } aop_e;

endpackage

// File: rtl/ode_fxmul.sv
module ode_fxmul #(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic signed [W-1:0] op_a,
  input  logic signed [W-1:0] op_b,
  output logic signed [W-1:0] prod
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] ext_a;
  logic signed [PW-1:0] ext_b;
  logic signed [PW-1:0] full;
  logic                 unused_prod_bits;

  always_comb begin
    ext_a = PW'(op_a);
    ext_b = PW'(op_b);
    full  = ext_a * ext_b;
  end

  // floor division by 2^FRAC, then keep W bits
  assign prod = full[FRAC+W-1:FRAC];
  assign unused_prod_bits = ^{full[PW-1:FRAC+W], full[FRAC-1:0]};
endmodule

// File: rtl/ode_alu.sv
module ode_alu
  import ode_stepper_pkg::*;
#(
  parameter int W = 16
) (
  input  aop_e                op,
  input  logic signed [W-1:0] op_a,
  input  logic signed [W-1:0] op_b,
  output logic signed [W-1:0] res,
  output logic                less
);
  always_comb begin
    less = (op_a < op_b);
    unique case (op)
      AOP_ADD: res = op_a + op_b;
      AOP_SUB: res = op_a - op_b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/ode_ctrl.sv
module ode_ctrl
  import ode_stepper_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   keep_going,
  output phase_e phase,
  output logic   load,
  output logic   commit,
  output logic   done
);
  phase_e phase_d;
  logic   done_d;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_IDLE: if (start) phase_d = PH_ONE;
      PH_ONE:  phase_d = PH_TWO;
      PH_TWO:  phase_d = PH_THR;
      PH_THR:  phase_d = PH_FOUR;
      PH_FOUR: phase_d = keep_going ? PH_ONE : PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
    done_d = (phase == PH_FOUR) && !keep_going;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phase_d;
      done  <= done_d;
    end
  end

  assign load   = (phase == PH_IDLE) && start;
  assign commit = (phase == PH_FOUR);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && !start) |=> (phase == PH_IDLE));
  // R7
  step_one_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ONE) |=> (phase == PH_TWO));
  // R7
  step_thr_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_THR) |=> (phase == PH_FOUR));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  loop_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FOUR && keep_going) |=> (phase == PH_ONE && !done));
endmodule

// File: rtl/ode_stepper.sv
module ode_stepper
  import ode_stepper_pkg::*;
#(
  parameter int W    = 16,
  parameter int FRAC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] u_in,
  input  logic signed [W-1:0] dx_in,
  input  logic signed [W-1:0] a_in,
  output logic signed [W-1:0] y_out,
  output logic                done
);
  localparam int NMUL = 2;
  localparam int NALU = 2;
  localparam logic signed [W-1:0] THREE = W'(3 << FRAC);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_n, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  phase_e phase;
  logic   load, commit, c_q;

  ode_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .keep_going (c_q),
    .phase      (phase),
    .load       (load),
    .commit     (commit),
    .done       (done)
  );

  // state and loop-invariant registers
  logic signed [W-1:0] x_q, y_q, u_q, dx_q, a_q;
  // intermediate registers
  logic signed [W-1:0] tx_q, udx_q, p1_q, ty_q, p2_q, uy_q, s1_q, xn_q;

  // shared units
  logic signed [W-1:0] mul_a [NMUL];
  logic signed [W-1:0] mul_b [NMUL];
  logic signed [W-1:0] mul_p [NMUL];
  aop_e                alu_op [NALU];
  logic signed [W-1:0] alu_a  [NALU];
  logic signed [W-1:0] alu_b  [NALU];
  logic signed [W-1:0] alu_r  [NALU];
  logic                alu_lt [NALU];

  for (genvar k = 0; k < NMUL; k++) begin : g_mul
    ode_fxmul #(.W(W), .FRAC(FRAC)) mul_i (
      .op_a (mul_a[k]),
      .op_b (mul_b[k]),
      .prod (mul_p[k])
    );
  end

  for (genvar k = 0; k < NALU; k++) begin : g_alu
    ode_alu #(.W(W)) alu_i (
      .op   (alu_op[k]),
      .op_a (alu_a[k]),
      .op_b (alu_b[k]),
      .res  (alu_r[k]),
      .less (alu_lt[k])
    );
  end

  logic unused_lt;
  assign unused_lt = alu_lt[1];

  // operand steering, fixed binding per control step
  always_comb begin
    for (int k = 0; k < NMUL; k++) begin
      mul_a[k] = '0;
      mul_b[k] = '0;
    end
    for (int k = 0; k < NALU; k++) begin
      alu_op[k] = AOP_ADD;
      alu_a[k]  = '0;
      alu_b[k]  = '0;
    end
    unique case (phase)
      PH_ONE: begin
        mul_a[0] = THREE;  mul_b[0] = x_q;
        mul_a[1] = u_q;    mul_b[1] = dx_q;
        alu_op[0] = AOP_ADD; alu_a[0] = x_q; alu_b[0] = dx_q;
      end
      PH_TWO: begin
        mul_a[0] = tx_q;   mul_b[0] = udx_q;
        mul_a[1] = THREE;  mul_b[1] = y_q;
        alu_op[0] = AOP_LT; alu_a[0] = xn_q; alu_b[0] = a_q;
      end
      PH_THR: begin
        mul_a[0] = ty_q;   mul_b[0] = dx_q;
        mul_a[1] = u_q;    mul_b[1] = dx_q;
        alu_op[0] = AOP_SUB; alu_a[0] = u_q; alu_b[0] = p1_q;
      end
      PH_FOUR: begin
        alu_op[0] = AOP_SUB; alu_a[0] = s1_q; alu_b[0] = p2_q;
        alu_op[1] = AOP_ADD; alu_a[1] = y_q;  alu_b[1] = uy_q;
      end
      default: ;
    endcase
  end

  logic en_one, en_two, en_thr;
  assign en_one = (phase == PH_ONE);
  assign en_two = (phase == PH_TWO);
  assign en_thr = (phase == PH_THR);

  // datapath registers without reset
  always_ff @(posedge clk) begin
    if (load) begin
      x_q  <= x_in;
      u_q  <= u_in;
      dx_q <= dx_in;
      a_q  <= a_in;
    end else if (commit) begin
      x_q <= xn_q;
      u_q <= alu_r[0];
    end
    if (en_one) begin
      tx_q  <= mul_p[0];
      udx_q <= mul_p[1];
      xn_q  <= alu_r[0];
    end
    if (en_two) begin
      p1_q <= mul_p[0];
      ty_q <= mul_p[1];
    end
    if (en_thr) begin
      p2_q <= mul_p[0];
      uy_q <= mul_p[1];
      s1_q <= alu_r[0];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      y_q <= '0;
      c_q <= 1'b0;
    end else begin
      if (load)        y_q <= y_in;
      else if (commit) y_q <= alu_r[1];
      if (en_two)      c_q <= alu_lt[0];
    end
  end

  assign y_out = y_q;

  // R2
  xnext_sum_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == PH_TWO) |-> (xn_q == x_q + dx_q));
  // R4
  x_commit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == PH_FOUR) |=> (x_q == $past(xn_q)));
  // R5
  exit_bound_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !(x_q < a_q));
  // R8
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (phase == PH_IDLE && !start) |=> $stable(y_q));
endmodule

// File: tb/ode_stepper_tb.sv
`timescale 1ns/1ps
module ode_stepper_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic signed [15:0] x_in, y_in, u_in, dx_in, a_in;
  logic signed [15:0] y_out;
  logic done;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ode_stepper dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .u_in(u_in), .dx_in(dx_in), .a_in(a_in),
    .y_out(y_out), .done(done)
  );

  // stimulus table: x, y, u, dx, a (Q8.8)
  localparam int NV = 7;
  localparam logic signed [15:0] VEC [NV][5] = '{
    '{ 16'sd0,     16'sd256,  16'sd0,    16'sd64,  16'sd256  },
    '{ 16'sd0,     16'sd256,  16'sd256,  16'sd32,  16'sd256  },
    '{ 16'sd512,   16'sd100, -16'sd50,   16'sd16,  16'sd256  },
    '{-16'sd256,   16'sd0,    16'sd128,  16'sd64,  16'sd0    },
    '{ 16'sd0,    -16'sd300,  16'sd200,  16'sd128, 16'sd640  },
    '{ 16'sd0,     16'sd50,   16'sd50,   16'sd100, 16'sd100  },
    '{-16'sd1000,  16'sd10,   16'sd5,    16'sd100, -16'sd500 }
  };

  function automatic logic signed [15:0] qmul(input logic signed [15:0] p,
                                              input logic signed [15:0] q);
    logic signed [31:0] full;
    full = 32'(p) * 32'(q);
    return full[23:8];
  endfunction

  // behavioural model of the requirements
  task automatic model(input logic signed [15:0] x0, y0, u0, dx, a,
                       output logic signed [15:0] yf, output int steps);
    logic signed [15:0] x, y, u, xn, un, yn;
    x = x0; y = y0; u = u0; steps = 0;
    forever begin
      xn = x + dx;
      un = u - qmul(qmul(16'sd768, x), qmul(u, dx)) - qmul(qmul(16'sd768, y), dx);
      yn = y + qmul(u, dx);
      x = xn; u = un; y = yn;
      steps++;
      if (!(xn < a) || steps > 1000) break;
    end
    yf = y;
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // launches a solve; poke > 0 injects a foreign start after that many cycles
  task automatic run(input int idx, input int poke,
                     output logic signed [15:0] yres, output int cyc);
    @(negedge clk);
    x_in = VEC[idx][0]; y_in = VEC[idx][1]; u_in = VEC[idx][2];
    dx_in = VEC[idx][3]; a_in = VEC[idx][4];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    x_in = 16'sd7; y_in = -16'sd99; u_in = 16'sd3; dx_in = 16'sd1; a_in = 16'sd9;
    cyc = 1;
    while (!done && cyc < 5000) begin
      start = (cyc == poke);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    yres = y_out;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R7 watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic signed [15:0] ye, yr, yhold;
    int ne, cyc;
    rst_n = 1'b0; start = 1'b0;
    x_in = '0; y_in = '0; u_in = '0; dx_in = '0; a_in = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(done == 1'b0, "R10 done after reset", int'(done), 0);
    chk(y_out == 16'sd0, "R10 y_out after reset", int'(y_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      model(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], ye, ne);
      run(i, 0, yr, cyc);
      // R3 R4 R9 result value
      chk(yr == ye, $sformatf("R3 R4 R9 y result vec %0d", i), int'(yr), int'(ye));
      // R2 R5 R7 step count seen through latency
      chk(cyc == 4 * ne + 1, $sformatf("R2 R5 R7 latency vec %0d", i), cyc, 4 * ne + 1);
      if (i == 2 || i == 5)
        chk(ne == 1 && cyc == 5, $sformatf("R6 single step vec %0d", i), cyc, 5);
      @(negedge clk);
      // R8 pulse width and hold
      chk(done == 1'b0, $sformatf("R8 done width vec %0d", i), int'(done), 0);
      yhold = y_out;
      repeat (6) @(negedge clk);
      chk(y_out == yhold, $sformatf("R8 y hold vec %0d", i), int'(y_out), int'(yhold));
    end

    // R1 start injected mid-run
    model(VEC[1][0], VEC[1][1], VEC[1][2], VEC[1][3], VEC[1][4], ye, ne);
    run(1, 6, yr, cyc);
    chk(yr == ye, "R1 mid-run start result", int'(yr), int'(ye));
    chk(cyc == 4 * ne + 1, "R1 mid-run start latency", cyc, 4 * ne + 1);
    @(negedge clk);
    chk(done == 1'b0, "R1 no restart after mid-run start", int'(done), 0);

    // R1 start on the final commit cycle
    model(VEC[0][0], VEC[0][1], VEC[0][2], VEC[0][3], VEC[0][4], ye, ne);
    run(0, 4 * ne, yr, cyc);
    chk(yr == ye, "R1 commit-cycle start result", int'(yr), int'(ye));
    chk(cyc == 4 * ne + 1, "R1 commit-cycle start latency", cyc, 4 * ne + 1);
    repeat (3) @(negedge clk);
    chk(y_out == ye, "R1 commit-cycle start no new run", int'(y_out), int'(ye));

    // R10 reset during a run, then a clean rerun
    @(negedge clk);
    x_in = VEC[4][0]; y_in = VEC[4][1]; u_in = VEC[4][2];
    dx_in = VEC[4][3]; a_in = VEC[4][4];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(y_out == 16'sd0 && done == 1'b0, "R10 reset mid-run", int'(y_out), 0);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(done == 1'b0, "R10 abandoned run stays quiet", int'(done), 0);
    model(VEC[6][0], VEC[6][1], VEC[6][2], VEC[6][3], VEC[6][4], ye, ne);
    run(6, 0, yr, cyc);
    chk(yr == ye, "R10 rerun result", int'(yr), int'(ye));

    summary();
    $finish;
  end
endmodule